// File: doc/BRIEF.md
# Three-Requester Fixed-Priority Arbiter

The block lets three clients take turns on one shared resource. Each client raises its request line and waits for its grant line. When no grant is active, the arbiter takes the most urgent pending request (`req_hi` before `req_mid` before `req_lo`) and raises that client's grant on the next clock edge. The grant then stays with that client for as long as it keeps its request high. A more urgent request that arrives in the meantime does not take the resource away.

When the owner drops its request, the arbiter returns to its idle state and drives no grant for one cycle. The next priority decision is made from that idle state, so two grants always have at least one empty cycle between them. All grants come from registers and depend only on the current state. Requests are treated as synchronous to `clk`. Request and grant are plain control pins with no valid/ready flow control: a client is stalled simply by not being granted.

Top module: `arb_fixed3`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, all three grant outputs are 0, whatever the requests are.
- R2: With no grant active and `req_hi` = 1, `gnt_hi` is 1 after the next rising clock edge, whatever `req_mid` and `req_lo` are.
- R3: With no grant active, `req_hi` = 0 and `req_mid` = 1, `gnt_mid` is 1 after the next rising clock edge, whatever `req_lo` is.
- R4: With no grant active and only `req_lo` = 1, `gnt_lo` is 1 after the next rising clock edge.
- R5: With no grant active and no request, all grants stay 0 after the next edge.
- R6: A granted client whose request is still 1 at a rising edge keeps its grant after that edge, even when a more urgent request is present.
- R7: A granted client whose request is 0 at a rising edge loses its grant at that edge, and no grant is active in the following cycle.
- R8: At most one grant output is 1 in any cycle.
- R9: A grant output rises only after a cycle in which no grant was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_hi | input | 1 | Request from the most urgent client |
| req_mid | input | 1 | Request from the middle-priority client |
| req_lo | input | 1 | Request from the least urgent client |
| gnt_hi | output | 1 | Grant to the most urgent client |
| gnt_mid | output | 1 | Grant to the middle-priority client |
| gnt_lo | output | 1 | Grant to the least urgent client |

## Verification
Every result of this block appears exactly one rising edge after the request pattern that causes it. This holds for a grant being issued, kept or released. The only exception is a new grant after a release, which needs two edges: one to fall to idle and one to decide. The bench changes the requests on a falling edge and samples the grants on the next falling edge. Each check therefore sees the state after exactly one decision, and handover sequences are walked edge by edge, with the idle cycle checked explicitly.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    PH_FREE = 1'b0,
    PH_HELD = 1'b1
  } phase_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NUM_REQ = 3
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] pick,
  output logic               any_req
);
  logic [NUM_REQ:0] above;

  assign above[0] = 1'b0;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chain
    assign pick[i]    = req[i] & ~above[i];
    assign above[i+1] = above[i] | req[i];
  end

  assign any_req = above[NUM_REQ];
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] pick,
  input  logic               any_req,
  output logic [NUM_REQ-1:0] owner
);
  phase_t             phase_q, phase_d;
  logic [NUM_REQ-1:0] owner_q, owner_d;
  logic               keep;

  assign keep = |(owner_q & req);

  always_comb begin
    phase_d = phase_q;
    owner_d = owner_q;
    case (phase_q)
      PH_FREE: begin
        if (any_req) begin
          phase_d = PH_HELD;
          owner_d = pick;
        end
      end
      PH_HELD: begin
        if (!keep) begin
          phase_d = PH_FREE;
          owner_d = '0;
        end
      end
      default: begin
        phase_d = PH_FREE;
        owner_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FREE;
      owner_q <= '0;
    end else begin
      phase_q <= phase_d;
      owner_q <= owner_d;
    end
  end

  assign owner = owner_q;
endmodule

// File: rtl/arb_fixed3.sv
module arb_fixed3 (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_mid,
  input  logic req_lo,
  output logic gnt_hi,
  output logic gnt_mid,
  output logic gnt_lo
);
  localparam int NUM_REQ = 3;

  logic [NUM_REQ-1:0] req_vec;
  logic [NUM_REQ-1:0] pick_vec;
  logic [NUM_REQ-1:0] gnt_vec;
  logic               any_req;

  assign req_vec = {req_lo, req_mid, req_hi};

  arb_prio_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .req     (req_vec),
    .pick    (pick_vec),
    .any_req (any_req)
  );

  arb_grant_fsm #(.NUM_REQ(NUM_REQ)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_vec),
    .pick    (pick_vec),
    .any_req (any_req),
    .owner   (gnt_vec)
  );

  assign gnt_hi  = gnt_vec[0];
  assign gnt_mid = gnt_vec[1];
  assign gnt_lo  = gnt_vec[2];
endmodule

// File: rtl/arb_fixed3_chk.sv
module arb_fixed3_chk (
  input logic clk,
  input logic rst_n,
  input logic req_hi,
  input logic req_mid,
  input logic req_lo,
  input logic gnt_hi,
  input logic gnt_mid,
  input logic gnt_lo
);
  logic [2:0] g;
  logic       none;
  assign g    = {gnt_lo, gnt_mid, gnt_hi};
  assign none = (g == 3'b000);

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (g == 3'b000); // R1
  end

  AST_PICK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (none && req_hi) |=> gnt_hi); // R2
  AST_PICK_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (none && !req_hi && req_mid) |=> gnt_mid); // R3
  AST_PICK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (none && !req_hi && !req_mid && req_lo) |=> gnt_lo); // R4
  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (none && !req_hi && !req_mid && !req_lo) |=> (g == 3'b000)); // R5
  AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_hi && req_hi) |=> gnt_hi); // R6
  AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_mid && req_mid) |=> gnt_mid); // R6
  AST_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_lo && req_lo) |=> gnt_lo); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_hi && !req_hi) || (gnt_mid && !req_mid) || (gnt_lo && !req_lo)) |=> (g == 3'b000)); // R7
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g)); // R8
  AST_GAP_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!none && !$stable(g)) |-> ($past(g) == 3'b000) || (g == 3'b000)); // R9
endmodule

bind arb_fixed3 arb_fixed3_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_hi  (req_hi),
  .req_mid (req_mid),
  .req_lo  (req_lo),
  .gnt_hi  (gnt_hi),
  .gnt_mid (gnt_mid),
  .gnt_lo  (gnt_lo)
);

// File: tb/tb_arb_fixed3.sv
module tb_arb_fixed3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req = 3'b000;   // bit0 hi, bit1 mid, bit2 lo
  logic gnt_hi, gnt_mid, gnt_lo;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  arb_fixed3 dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_hi  (req[0]),
    .req_mid (req[1]),
    .req_lo  (req[2]),
    .gnt_hi  (gnt_hi),
    .gnt_mid (gnt_mid),
    .gnt_lo  (gnt_lo)
  );

  task automatic check(input logic [2:0] exp, input string tag);
    logic [2:0] got;
    got = {gnt_lo, gnt_mid, gnt_hi};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: grants(lo,mid,hi)=%b expected %b", tag, got, exp);
    end
    checks++;
    if ($countones(got) > 1) begin
      fails++;
      $display("FAIL R8: grants(lo,mid,hi)=%b expected at most one set", got);
    end
  endtask

  // apply a request pattern, let one rising edge pass, then compare
  task automatic step(input logic [2:0] r, input logic [2:0] exp, input string tag);
    req = r;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic t_reset();
    req = 3'b111;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(3'b000, "R1 during reset");
    req = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);
    check(3'b000, "R1 after reset");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) step(3'b000, 3'b000, "R5 idle");
  endtask

  task automatic t_hi_wins();
    step(3'b111, 3'b001, "R2 all requests");
    step(3'b111, 3'b001, "R6 hi kept");
    step(3'b110, 3'b000, "R7 hi released");
    step(3'b000, 3'b000, "R5 back to idle");
  endtask

  task automatic t_mid_wins();
    step(3'b110, 3'b010, "R3 mid over lo");
    step(3'b000, 3'b000, "R7 mid released");
  endtask

  task automatic t_lo_not_preempted();
    step(3'b100, 3'b100, "R4 lo alone");
    step(3'b101, 3'b100, "R6 lo kept while hi waits");
    step(3'b111, 3'b100, "R6 lo kept while hi and mid wait");
    step(3'b011, 3'b000, "R7 idle gap after lo");
    step(3'b011, 3'b001, "R2 hi after gap");
    step(3'b000, 3'b000, "R7 hi released");
  endtask

  task automatic t_mid_handoff();
    step(3'b010, 3'b010, "R3 mid alone");
    step(3'b011, 3'b010, "R6 mid kept while hi waits");
    step(3'b001, 3'b000, "R9 idle before hi");
    step(3'b001, 3'b001, "R2 hi after gap");
    step(3'b100, 3'b000, "R9 idle before lo");
    step(3'b100, 3'b100, "R4 lo after gap");
    step(3'b000, 3'b000, "R7 lo released");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_hi_wins();
    t_mid_wins();
    t_lo_not_preempted();
    t_mid_handoff();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule